// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block lets a clocked system read an external asynchronous parallel ROM that supports fast page reads. A request gives a start location, a burst length and a width mode. The controller then drives the ROM enables, the width select and the address lines itself. It waits a number of clock cycles before it samples each location, and it hands every sampled value to a consumer over a valid/ready stream.

A page is a group of adjacent locations that share their upper address bits. The first location of a burst pays the full random-access wait. It also pays the output-enable wait, and whichever wait is longer applies. A later location in the same page needs only the short page-access wait. A step into a new page pays the full random-access wait again. All waits are nanosecond figures turned into whole clock cycles from the clock-period parameter. When a burst ends, the controller releases both enables and holds them released through a bus turnaround before it accepts new work.

Top module: `prom_page_reader`

## Requirements
- R1: During and right after reset, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Every wait is ceil(ns / CLK_PERIOD_NS) cycles, and never less than 1. The first location of a burst is sampled max(access wait, output-enable wait) cycles after the accepting edge, and it shows on `rsp_valid` from that edge on. At 20 ns and the default timings this is 5 cycles.
- R3: A later location whose page is the same as the one before it is sampled page-wait cycles after the previous sample. At the defaults this is 2 cycles.
- R4: A page is 8 words in word mode, with location bits [2:0] inside the page. In byte mode it is 16 bytes, with location bits [3:0] inside the page. A location that enters a new page is sampled access-wait cycles after the previous sample, which is 5 cycles at the defaults.
- R5: Byte mode (`req_byte`=1) works as follows:
  - `rom_byte_n` is 0.
  - `rom_addr` is location[ADDR_W:1].
  - `rom_am1_o` is location[0], and `rom_am1_oe` is 1 while the ROM is enabled.
  - `rsp_data` is {8'h00, rom_dq[7:0]}.
- R6: Word mode (`req_byte`=0) works as follows:
  - `rom_byte_n` is 1.
  - `rom_addr` is location[ADDR_W-1:0].
  - `rom_am1_oe` is 0.
  - `rsp_data` is the full `rom_dq`.
- R7: A request returns `req_len`+1 beats from consecutive locations, starting at `req_addr`. `rsp_last` is 1 on the final beat only.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` and `rsp_last` hold still and the ROM address does not advance. No beat is lost or repeated.
- R9: Whenever `req_ready` is 1, both enables are 1. After the final sample, both enables are 1 and `req_ready` is 0 for at least the turnaround-wait cycles.
- R10: While a burst runs, `req_ready` is 0 and `req_valid` has no effect. No extra beats appear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_addr | input | ADDR_W+1 | Start location (a word index or a byte index) |
| req_len | input | LEN_W | Beats in the burst minus one |
| req_byte | input | 1 | 1 selects byte mode, 0 selects word mode |
| rsp_valid | output | 1 | Returned beat is valid |
| rsp_ready | input | 1 | Consumer takes the beat |
| rsp_data | output | 16 | Returned word, or a byte in the low half |
| rsp_last | output | 1 | Final beat of the burst |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, low for bytes |
| rom_addr | output | ADDR_W | ROM address lines |
| rom_am1_o | output | 1 | Value driven onto the shared top data pin in byte mode |
| rom_am1_oe | output | 1 | Drive enable for that shared pin |
| rom_dq | input | 16 | ROM data lines |

## Verification
The bench drives at the falling edge and counts rising edges. It records the edge on which a request is accepted. With the consumer always ready, the first beat must appear exactly max(access, output-enable) cycles after that edge. Each later beat must appear a page-wait or access-wait gap after the one before it, depending on whether its page changed. The ROM model returns a poison value if the controller samples before the address and enable times in nanoseconds have passed. Under random backpressure the gaps are not checked, but the held beat must stay the same.

// File: rtl/prom_pkg.sv
`timescale 1ns/1ps
package prom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TURN = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [15:0] data;
        logic        last;
    } rsp_beat_t;

    // Whole clock cycles covering a delay in ns, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_lat_timer.sv
`timescale 1ns/1ps
module prom_lat_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2: a loaded nonzero wait is never skipped
    p_wait_not_skipped_r2: assert property (@(posedge clk) disable iff (rst)
        load && (load_val != '0) |=> !expired);
endmodule

// File: rtl/prom_loc_gen.sv
`timescale 1ns/1ps
module prom_loc_gen #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W:0]   load_loc,
    input  logic              load_byte,
    input  logic              step,
    output logic              byte_mode,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_am1,
    output logic              next_crosses
);
    logic [ADDR_W:0] loc_q;
    logic            byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q  <= '0;
            byte_q <= 1'b0;
        end else if (load) begin
            loc_q  <= load_loc;
            byte_q <= load_byte;
        end else if (step) begin
            loc_q  <= loc_q + 1'b1;
        end
    end

    assign byte_mode = byte_q;
    assign rom_addr  = byte_q ? loc_q[ADDR_W:1] : loc_q[ADDR_W-1:0];
    assign rom_am1   = byte_q & loc_q[0];

    // Next increment leaves the page when every in-page bit is one.
    assign next_crosses = byte_q ? (&loc_q[PAGE_W:0]) : (&loc_q[PAGE_W-1:0]);

    // R4: a step out of a full page clears the in-page word bits
    p_cross_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        step && !load && next_crosses |=> rom_addr[PAGE_W-1:0] == '0);
endmodule

// File: rtl/prom_rsp_reg.sv
`timescale 1ns/1ps
module prom_rsp_reg
    import prom_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  logic [15:0] cap_data,
    input  logic        cap_last,
    input  logic        cap_byte,
    input  logic        rsp_ready,
    output logic        rsp_valid,
    output logic [15:0] rsp_data,
    output logic        rsp_last,
    output logic        slot_free
);
    rsp_beat_t beat_q;
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (cap) begin
            valid_q <= 1'b1;
            beat_q  <= '{data: cap_data, last: cap_last};
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign slot_free = !valid_q || rsp_ready;
    assign rsp_valid = valid_q;
    assign rsp_data  = beat_q.data;
    assign rsp_last  = beat_q.last;

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        valid_q && !rsp_ready |=> valid_q && $stable(beat_q));
    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
        cap |-> slot_free);
    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        cap && cap_byte |=> rsp_data[15:8] == 8'h00);
endmodule

// File: rtl/prom_page_reader.sv
`timescale 1ns/1ps
module prom_page_reader
    import prom_pkg::*;
#(
    parameter int unsigned ADDR_W        = 24,
    parameter int unsigned LEN_W         = 8,
    parameter int unsigned PAGE_W        = 3,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_ACC_NS      = 100,
    parameter int unsigned T_PAGE_NS     = 35,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_HIZ_NS      = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_byte,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [15:0]       rsp_data,
    output logic              rsp_last,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_byte_n,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_am1_o,
    output logic              rom_am1_oe,
    input  logic [15:0]       rom_dq
);
    localparam int unsigned CYC_ACC   = ns_to_cycles(T_ACC_NS,  CLK_PERIOD_NS);
    localparam int unsigned CYC_PAGE  = ns_to_cycles(T_PAGE_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_OE    = ns_to_cycles(T_OE_NS,   CLK_PERIOD_NS);
    localparam int unsigned CYC_HIZ   = ns_to_cycles(T_HIZ_NS,  CLK_PERIOD_NS);
    localparam int unsigned CYC_FIRST = max_u(CYC_ACC, CYC_OE);
    localparam int unsigned CYC_MAX   = max_u(max_u(CYC_FIRST, CYC_PAGE), CYC_HIZ);
    localparam int unsigned CNT_W     = $clog2(CYC_MAX + 1);

    localparam logic [CNT_W-1:0] LD_FIRST = CNT_W'(CYC_FIRST - 1);
    localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(CYC_ACC - 1);
    localparam logic [CNT_W-1:0] LD_PAGE  = CNT_W'(CYC_PAGE - 1);
    localparam logic [CNT_W-1:0] LD_HIZ   = CNT_W'(CYC_HIZ - 1);

    rd_state_e        state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic             accept, capture, last_beat, step;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             byte_mode, next_crosses, slot_free;
    logic [15:0]      cap_data;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign last_beat = (rem_q == '0);
    assign capture   = (state_q == ST_WAIT) && tmr_expired && slot_free;
    assign step      = capture && !last_beat;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)                 state_d = ST_WAIT;
            ST_WAIT: if (capture && last_beat)   state_d = ST_TURN;
            ST_TURN: if (tmr_expired)            state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = LD_FIRST;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = LD_FIRST;
        end else if (capture) begin
            tmr_load = 1'b1;
            if (last_beat)         tmr_val = LD_HIZ;
            else if (next_crosses) tmr_val = LD_ACC;
            else                   tmr_val = LD_PAGE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)    rem_q <= req_len;
            else if (step) rem_q <= rem_q - 1'b1;
        end
    end

    prom_lat_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    prom_loc_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_loc (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .load_loc     (req_addr),
        .load_byte    (req_byte),
        .step         (step),
        .byte_mode    (byte_mode),
        .rom_addr     (rom_addr),
        .rom_am1      (rom_am1_o),
        .next_crosses (next_crosses)
    );

    assign cap_data = byte_mode ? {8'h00, rom_dq[7:0]} : rom_dq;

    prom_rsp_reg u_rsp (
        .clk       (clk),
        .rst       (rst),
        .cap       (capture),
        .cap_data  (cap_data),
        .cap_last  (last_beat),
        .cap_byte  (byte_mode),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .slot_free (slot_free)
    );

    assign rom_ce_n   = (state_q != ST_WAIT);
    assign rom_oe_n   = (state_q != ST_WAIT);
    assign rom_byte_n = !byte_mode;
    assign rom_am1_oe = byte_mode && (state_q == ST_WAIT);

    p_accept_bus_idle_r9: assert property (@(posedge clk) disable iff (rst)
        accept |-> rom_ce_n && rom_oe_n);
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        !rom_ce_n |-> !req_ready);
    p_addr_stall_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready && !rom_ce_n |=> $stable(rom_addr) && $stable(rom_am1_o));
    p_capture_under_oe_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(!rom_oe_n));
    p_word_pin_released_r6: assert property (@(posedge clk) disable iff (rst)
        rom_byte_n |-> !rom_am1_oe);
endmodule

// File: tb/tb_prom_page_reader.sv
`timescale 1ns/1ps
module tb_prom_page_reader;
    localparam int AW = 24;
    localparam int PER = 20;
    // Expected waits from R2..R4 at a 20 ns clock
    localparam int W_FIRST = 5;
    localparam int W_PAGE  = 2;
    localparam int W_ACC   = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_byte = 1'b0;
    logic [AW:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic rsp_valid, rsp_ready = 1'b1, rsp_last;
    logic [15:0] rsp_data;
    logic rom_ce_n, rom_oe_n, rom_byte_n, rom_am1_o, rom_am1_oe;
    logic [AW-1:0] rom_addr;
    logic [15:0] rom_dq = '0;

    prom_page_reader dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_byte_n(rom_byte_n), .rom_addr(rom_addr), .rom_am1_o(rom_am1_o),
        .rom_am1_oe(rom_am1_oe), .rom_dq(rom_dq)
    );

    always #(PER/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, ref_cyc = 0;
    bit stall_on = 1'b0, finished = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic        l;
        int          gap;
        int          rq_data;
        int          rq_gap;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] rom_word(input logic [AW-1:0] w);
        return w[15:0] ^ {w[7:0], w[23:16]} ^ 16'h3C5A;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // ROM model: poison data when sampled before its times have elapsed
    time t_up = 0, t_any = 0, t_oe = 0;
    always @(rom_addr[AW-1:3]) begin t_up = $time; t_any = $time; end
    always @(rom_addr[2:0] or rom_am1_o) t_any = $time;
    always @(negedge rom_ce_n) t_up = $time;
    always @(negedge rom_oe_n) t_oe = $time;
    always @(negedge clk) begin
        time tp;
        logic ok;
        logic [15:0] w;
        tp = $time + PER/2;
        ok = !rom_ce_n && !rom_oe_n && (tp - t_up >= 100) &&
             (tp - t_any >= 35) && (tp - t_oe >= 30);
        w  = rom_word(rom_addr);
        if (!rom_byte_n) rom_dq = w;
        else if (!ok)    rom_dq = 16'hBAD0;
        else             rom_dq = w;
        if (rom_byte_n == 1'b0)
            rom_dq = {8'hA5, ok ? (rom_am1_o ? w[15:8] : w[7:0]) : 8'hB0};
        else if (!ok)
            rom_dq = 16'hBAD0;
    end

    // Consumer: always ready, or random backpressure
    initial begin
        logic [7:0] lf = 8'h5B;
        forever begin
            @(posedge clk); #2;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            rsp_ready = stall_on ? lf[0] : 1'b1;
        end
    end

    // Monitor / scoreboard
    initial begin
        exp_t e;
        bit held = 1'b0;
        logic [15:0] held_d = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (held && rsp_valid)   // R8: held beat unchanged
                    check(rsp_data == held_d, "R8", "held data", rsp_data, held_d);
                held = rsp_valid && !rsp_ready;
                held_d = rsp_data;
                if (req_ready)           // R9: idle bus released
                    check(rom_ce_n && rom_oe_n, "R9", "enables while ready",
                          {rom_ce_n, rom_oe_n}, 2'b11);
                if (rsp_valid && rsp_ready) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R10", "unexpected beat", rsp_data, 0);
                    end else begin
                        e = q.pop_front();
                        check(rsp_data == e.d, $sformatf("R%0d", e.rq_data),
                              "data", rsp_data, e.d);
                        check(rsp_last == e.l, "R7", "last flag", rsp_last, e.l);
                        if (e.gap != 0) begin
                            check(cyc - ref_cyc == e.gap, $sformatf("R%0d", e.rq_gap),
                                  "cycle gap", cyc - ref_cyc, e.gap);
                            if (e.l)     // R9 turnaround after final sample
                                check(rom_ce_n && rom_oe_n && !req_ready, "R9",
                                      "turnaround", {rom_ce_n, rom_oe_n, req_ready}, 3'b110);
                        end
                    end
                    ref_cyc = cyc;
                end
            end
        end
    end

    task automatic issue(input logic [AW:0] a, input int len, input logic bm, input bit timed);
        for (int i = 0; i <= len; i++) begin
            exp_t e;
            logic [AW:0] loc, prv;
            logic [15:0] w;
            loc = a + (AW+1)'(i);
            prv = loc - 1'b1;
            if (bm) begin
                w = rom_word(loc[AW:1]);
                e.d = {8'h00, loc[0] ? w[15:8] : w[7:0]};
                e.rq_data = 5;
            end else begin
                e.d = rom_word(loc[AW-1:0]);
                e.rq_data = 6;
            end
            e.l = (i == len);
            if (i == 0) begin e.gap = W_FIRST; e.rq_gap = 2; end
            else if ((bm && loc[3:0] == 4'h0) || (!bm && loc[2:0] == 3'h0) ||
                     (loc[AW:4] != prv[AW:4])) begin
                e.gap = W_ACC; e.rq_gap = 4;
            end else begin e.gap = W_PAGE; e.rq_gap = 3; end
            if (!timed) e.gap = 0;
            q.push_back(e);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_len = 8'(len); req_byte = bm; req_valid = 1'b1;
        ref_cyc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (q.size() != 0 || !req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R7 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check(rom_ce_n && rom_oe_n, "R1", "enables in reset", {rom_ce_n, rom_oe_n}, 2'b11);
        check(!rsp_valid && req_ready, "R1", "handshake in reset", {rsp_valid, req_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        check(rom_ce_n && !rsp_valid && req_ready, "R1", "after reset",
              {rom_ce_n, rsp_valid, req_ready}, 3'b101);

        // R2 R3 R6 R7: word burst inside one page
        issue(25'h000010, 3, 1'b0, 1'b1);
        check(rom_byte_n && !rom_am1_oe, "R6", "word pins", {rom_byte_n, rom_am1_oe}, 2'b10);
        wait_done();
        // R4: word burst crossing a page
        issue(25'h000106, 4, 1'b0, 1'b1);
        wait_done();
        // R4 R5: byte burst crossing a 16-byte page
        issue(25'h00001E, 3, 1'b1, 1'b1);
        check(!rom_byte_n && rom_am1_oe, "R5", "byte pins", {rom_byte_n, rom_am1_oe}, 2'b01);
        wait_done();
        // R7: single beat
        issue(25'h0ABCDE, 0, 1'b0, 1'b1);
        wait_done();
        // R8: backpressure, word then byte
        stall_on = 1'b1;
        issue(25'h0012F9, 12, 1'b0, 1'b0);
        wait_done();
        issue(25'h1003FB, 20, 1'b1, 1'b0);
        wait_done();
        stall_on = 1'b0;
        repeat (3) @(negedge clk);
        // R10: requests during a busy burst are ignored
        issue(25'h000200, 7, 1'b0, 1'b1);
        req_addr = 25'h055555; req_len = 8'd3; req_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check(!req_ready, "R10", "ready while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        check(!rsp_valid && q.size() == 0, "R10", "no extra beats", rsp_valid, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule